// File: doc/BRIEF.md
# Legacy Bridge Request Isolation Queue

This block sits on a downstream request path, in front of a bridge to a legacy bus that can neither retry nor split a transaction. Each arriving request is classified by its target identifier. Requests for the legacy bridge go into a small queue of their own. Every other request goes into a separate pass-through queue. Because of this split, a stalled legacy bridge can never hold up traffic meant for devices further down the chain, including devices that share a node with the bridge.

The block also guards the bridge. Only non-posted requests issued by the host may reach it. Posted requests and requests from peer devices are dropped, and the block reports the reason. The number of bridge requests in flight is capped at a known value, one by default. A slot is counted from the moment the block accepts a request. The slot is freed when the bridge returns a completion that carries the same tag. A completion whose tag matches nothing in flight is flagged as an error. The legacy bus completes each transaction before it starts the next, so the bridge queue stays strictly first-in first-out.

Top module: `lbr_isolation_queue`

## Requirements
- R1: A request with a known target other than the bridge (target id below NUM_TGT and not BRIDGE_ID, default 5) is written into the bypass queue and leaves it on the byp_* port in arrival order, with its peer flag, posted flag, target and tag unchanged. This applies whether it comes from the host or from a peer.
- R2: A non-posted request from the host to target BRIDGE_ID is written into the bridge queue and leaves it on br_valid/br_tag in arrival order.
- R3: A host request to BRIDGE_ID with the posted flag set is dropped, and rej_code is 1.
- R4: A peer request (in_src_peer=1) to BRIDGE_ID is dropped, and rej_code is 2. The peer reason takes precedence over the posted reason.
- R5: A request whose target id is NUM_TGT (default 6) or higher is dropped, and rej_code is 3. This reason takes precedence over all others.
- R6: A dropped request raises rej_valid in the same cycle, with rej_tag equal to in_tag. in_ready is high in that cycle, and neither queue is written.
- R7: A bridge request is accepted only while fewer than MAX_OUT (default 1) bridge requests are in flight and the bridge queue (depth 1) has room. Otherwise in_ready is low for that request.
- R8: For a request bound for the bypass queue, in_ready is high exactly when the bypass queue (depth 4) is not full, whatever the state of the bridge side.
- R9: A completion (cpl_valid) whose cpl_tag matches an in-flight bridge request frees that slot. A bridge request can then be accepted from the next cycle on.
- R10: A completion whose tag matches no in-flight bridge request raises cpl_err in the same cycle and frees nothing.
- R11: After reset, both queues are empty and no bridge request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Incoming request accepted or dropped |
| in_src_peer | input | 1 | 1 = request issued by a peer, 0 = by the host |
| in_tgt | input | TGT_W | Target identifier |
| in_posted | input | 1 | 1 = posted request |
| in_tag | input | TAG_W | Request tag |
| byp_valid | output | 1 | Bypass queue head valid |
| byp_ready | input | 1 | Downstream takes bypass head |
| byp_src_peer | output | 1 | Peer flag of bypass head |
| byp_tgt | output | TGT_W | Target of bypass head |
| byp_posted | output | 1 | Posted flag of bypass head |
| byp_tag | output | TAG_W | Tag of bypass head |
| br_valid | output | 1 | Bridge queue head valid |
| br_ready | input | 1 | Bridge takes queue head |
| br_tag | output | TAG_W | Tag of bridge queue head |
| cpl_valid | input | 1 | Completion returned by the bridge |
| cpl_tag | input | TAG_W | Tag of the returned completion |
| cpl_err | output | 1 | Completion matched no in-flight request |
| rej_valid | output | 1 | Request dropped this cycle |
| rej_tag | output | TAG_W | Tag of the dropped request |
| rej_code | output | 2 | 1 posted, 2 peer, 3 unknown target |

## Verification
The routing logic is driven with four kinds of traffic. Host and peer requests to ordinary targets show that the bridge checks apply only to the bridge target. Posted, peer and peer-posted requests to the bridge show the reject precedence. Out-of-range targets show that the range check comes before every other check. A long random mix of all of these, with completions that sometimes match and sometimes do not, checks more. It shows that bypass admission tracks only bypass occupancy while the bridge slot is held. It also shows that a freed slot is usable one cycle after its completion.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  typedef enum logic [1:0] {
    REJ_NONE   = 2'd0,
    REJ_POSTED = 2'd1,
    REJ_PEER   = 2'd2,
    REJ_TARGET = 2'd3
  } lbr_rej_e;

  typedef enum logic [1:0] {
    RT_BYPASS = 2'd0,
    RT_BRIDGE = 2'd1,
    RT_DROP   = 2'd2
  } lbr_route_e;

endpackage

// File: rtl/lbr_classifier.sv
module lbr_classifier
  import lbr_pkg::*;
#(
  parameter int TGT_W     = 3,
  parameter int NUM_TGT   = 6,
  parameter int BRIDGE_ID = 5
) (
  input  logic [TGT_W-1:0] tgt,
  input  logic             src_peer,
  input  logic             posted,
  output lbr_route_e       route,
  output lbr_rej_e         reason
);

  localparam logic [TGT_W-1:0] BridgeTgt = TGT_W'(BRIDGE_ID);

  always_comb begin
    route  = RT_BYPASS;
    reason = REJ_NONE;
    if (int'(tgt) >= NUM_TGT) begin
      route  = RT_DROP;
      reason = REJ_TARGET;
    end else if (tgt == BridgeTgt) begin
      if (src_peer) begin
        route  = RT_DROP;
        reason = REJ_PEER;
      end else if (posted) begin
        route  = RT_DROP;
        reason = REJ_POSTED;
      end else begin
        route  = RT_BRIDGE;
      end
    end
  end

endmodule

// File: rtl/lbr_fifo.sv
module lbr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LastPtr = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FullCnt = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full      = (cnt_q == FullCnt);
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign do_push   = push && !full;
  assign do_pop    = pop && out_valid;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LastPtr) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LastPtr) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  AST_FIFO_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop) |=> (out_valid && $stable(out_data))); // R1

endmodule

// File: rtl/lbr_cpl_tracker.sv
module lbr_cpl_tracker #(
  parameter int TAG_W = 4,
  parameter int SLOTS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  output logic             has_slot,
  output logic             cpl_err
);

  logic [SLOTS-1:0] vld_q, vld_d, hit, free_sel, alloc_sel;
  logic [TAG_W-1:0] tag_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_hit
    assign hit[i] = vld_q[i] && (tag_q[i] == cpl_tag);
  end

  always_comb begin
    logic got_free, got_alloc;
    got_free  = 1'b0;
    got_alloc = 1'b0;
    free_sel  = '0;
    alloc_sel = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (cpl_valid && hit[i] && !got_free) begin
        free_sel[i] = 1'b1;
        got_free    = 1'b1;
      end
      if (!vld_q[i] && !got_alloc) begin
        alloc_sel[i] = 1'b1;
        got_alloc    = 1'b1;
      end
    end
  end

  assign has_slot = !(&vld_q);
  assign cpl_err  = cpl_valid && !(|hit);

  always_comb begin
    vld_d = vld_q & ~free_sel;
    if (alloc) vld_d = vld_d | alloc_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (alloc && alloc_sel[i]) tag_q[i] <= alloc_tag;
    end
  end

  AST_ALLOC_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> has_slot); // R7

  AST_CPL_ERR_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_err && !alloc) |=> (vld_q == $past(vld_q))); // R10

  AST_CPL_HIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_err && !alloc) |=> ($countones(vld_q) + 1 == $countones($past(vld_q)))); // R9

endmodule

// File: rtl/lbr_isolation_queue.sv
module lbr_isolation_queue
  import lbr_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int TGT_W     = 3,
  parameter int NUM_TGT   = 6,
  parameter int BRIDGE_ID = 5,
  parameter int BYP_DEPTH = 4,
  parameter int BR_DEPTH  = 1,
  parameter int MAX_OUT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_src_peer,
  input  logic [TGT_W-1:0] in_tgt,
  input  logic             in_posted,
  input  logic [TAG_W-1:0] in_tag,
  output logic             byp_valid,
  input  logic             byp_ready,
  output logic             byp_src_peer,
  output logic [TGT_W-1:0] byp_tgt,
  output logic             byp_posted,
  output logic [TAG_W-1:0] byp_tag,
  output logic             br_valid,
  input  logic             br_ready,
  output logic [TAG_W-1:0] br_tag,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  output logic             cpl_err,
  output logic             rej_valid,
  output logic [TAG_W-1:0] rej_tag,
  output logic [1:0]       rej_code
);

  localparam int BYP_W = 2 + TGT_W + TAG_W;
  localparam logic [TGT_W-1:0] BridgeTgt = TGT_W'(BRIDGE_ID);

  lbr_route_e       route;
  lbr_rej_e         reason;
  logic             byp_full, br_full, tr_has_slot, br_can;
  logic             byp_push, br_push;
  logic [BYP_W-1:0] byp_wdata, byp_rdata;

  lbr_classifier #(
    .TGT_W(TGT_W), .NUM_TGT(NUM_TGT), .BRIDGE_ID(BRIDGE_ID)
  ) u_cls (
    .tgt(in_tgt), .src_peer(in_src_peer), .posted(in_posted),
    .route(route), .reason(reason)
  );

  assign br_can = tr_has_slot && !br_full;

  always_comb begin
    unique case (route)
      RT_DROP:   in_ready = 1'b1;
      RT_BRIDGE: in_ready = br_can;
      default:   in_ready = !byp_full;
    endcase
  end

  assign byp_push  = in_valid && in_ready && (route == RT_BYPASS);
  assign br_push   = in_valid && in_ready && (route == RT_BRIDGE);
  assign rej_valid = in_valid && (route == RT_DROP);
  assign rej_tag   = in_tag;
  assign rej_code  = rej_valid ? reason : REJ_NONE;
  assign byp_wdata = {in_src_peer, in_posted, in_tgt, in_tag};

  lbr_fifo #(.W(BYP_W), .DEPTH(BYP_DEPTH)) u_byp_q (
    .clk(clk), .rst_n(rst_n),
    .push(byp_push), .push_data(byp_wdata), .full(byp_full),
    .pop(byp_ready), .out_valid(byp_valid), .out_data(byp_rdata)
  );

  assign {byp_src_peer, byp_posted, byp_tgt, byp_tag} = byp_rdata;

  lbr_fifo #(.W(TAG_W), .DEPTH(BR_DEPTH)) u_br_q (
    .clk(clk), .rst_n(rst_n),
    .push(br_push), .push_data(in_tag), .full(br_full),
    .pop(br_ready), .out_valid(br_valid), .out_data(br_tag)
  );

  lbr_cpl_tracker #(.TAG_W(TAG_W), .SLOTS(MAX_OUT)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .alloc(br_push), .alloc_tag(in_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .has_slot(tr_has_slot), .cpl_err(cpl_err)
  );

  AST_REJ_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (in_ready && !byp_push && !br_push)); // R6

  AST_BR_ONLY_HOST_NP: assert property (@(posedge clk) disable iff (!rst_n)
    br_push |-> (!in_posted && !in_src_peer && in_tgt == BridgeTgt)); // R2

  AST_BYP_NEVER_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    byp_push |-> (in_tgt != BridgeTgt && int'(in_tgt) < NUM_TGT)); // R1

  AST_BYP_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && route == RT_BYPASS && !byp_full) |-> in_ready); // R8

endmodule

// File: tb/lbr_isolation_queue_test.sv
`timescale 1ns/1ps
module lbr_isolation_queue_test;

  localparam int TAG_W = 4;
  localparam int TGT_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_src_peer, in_posted, byp_ready, br_ready, cpl_valid;
  logic [TGT_W-1:0] in_tgt;
  logic [TAG_W-1:0] in_tag, cpl_tag;
  logic in_ready, byp_valid, byp_src_peer, byp_posted, br_valid, cpl_err, rej_valid;
  logic [TGT_W-1:0] byp_tgt;
  logic [TAG_W-1:0] byp_tag, br_tag, rej_tag;
  logic [1:0] rej_code;

  int checks = 0;
  int errors = 0;

  logic [8:0] m_byp[$];
  logic [3:0] m_br[$];
  logic [3:0] m_out[$];

  always #4 clk = ~clk;

  lbr_isolation_queue uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_src_peer(in_src_peer),
    .in_tgt(in_tgt), .in_posted(in_posted), .in_tag(in_tag),
    .byp_valid(byp_valid), .byp_ready(byp_ready), .byp_src_peer(byp_src_peer),
    .byp_tgt(byp_tgt), .byp_posted(byp_posted), .byp_tag(byp_tag),
    .br_valid(br_valid), .br_ready(br_ready), .br_tag(br_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_err(cpl_err),
    .rej_valid(rej_valid), .rej_tag(rej_tag), .rej_code(rej_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit iv, input bit peer, input int tgt, input bit posted,
                     input int tag, input bit bypr, input bit brr,
                     input bit cv, input int ctag);
    bit unk, isbr, rej, e_ready, found;
    int code, idx;
    string rq;
    @(negedge clk);
    in_valid = iv; in_src_peer = peer; in_tgt = TGT_W'(tgt); in_posted = posted;
    in_tag = TAG_W'(tag); byp_ready = bypr; br_ready = brr;
    cpl_valid = cv; cpl_tag = TAG_W'(ctag);
    #3;
    unk  = (tgt >= 6);
    isbr = !unk && (tgt == 5);
    rej  = unk || (isbr && (peer || posted));
    code = unk ? 3 : (peer ? 2 : 1);
    e_ready = rej ? 1'b1 : (isbr ? (m_out.size() < 1 && m_br.size() < 1) : (m_byp.size() < 4));
    found = 1'b0; idx = 0;
    for (int i = 0; i < m_out.size(); i++)
      if (!found && m_out[i] == TAG_W'(ctag)) begin found = 1'b1; idx = i; end
    // R7/R9 bridge admission, R8 bypass admission
    if (rej)       chk(in_ready == 1'b1, "R6 in_ready", in_ready, 1);
    else if (isbr) chk(in_ready == e_ready, "R7/R9 in_ready", in_ready, e_ready);
    else           chk(in_ready == e_ready, "R8 in_ready", in_ready, e_ready);
    chk(rej_valid == (iv && rej), "R6 rej_valid", rej_valid, iv && rej);
    if (iv && rej) begin
      rq = (code == 3) ? "R5 rej_code" : (code == 2) ? "R4 rej_code" : "R3 rej_code";
      chk(rej_code == 2'(code), rq, rej_code, code);
      chk(rej_tag == TAG_W'(tag), "R6 rej_tag", rej_tag, tag);
    end
    chk(byp_valid == (m_byp.size() > 0), "R1 byp_valid", byp_valid, m_byp.size() > 0);
    if (m_byp.size() > 0)
      chk({byp_src_peer, byp_posted, byp_tgt, byp_tag} == m_byp[0], "R1 byp_data",
          {byp_src_peer, byp_posted, byp_tgt, byp_tag}, m_byp[0]);
    chk(br_valid == (m_br.size() > 0), "R2 br_valid", br_valid, m_br.size() > 0);
    if (m_br.size() > 0) chk(br_tag == m_br[0], "R2 br_tag", br_tag, m_br[0]);
    chk(cpl_err == (cv && !found), "R10 cpl_err", cpl_err, cv && !found);
    if (bypr && m_byp.size() > 0) void'(m_byp.pop_front());
    if (brr && m_br.size() > 0)   void'(m_br.pop_front());
    if (cv && found) m_out.delete(idx);
    if (iv && !rej && e_ready) begin
      if (isbr) begin m_br.push_back(TAG_W'(tag)); m_out.push_back(TAG_W'(tag)); end
      else m_byp.push_back({peer, posted, TGT_W'(tgt), TAG_W'(tag)});
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_src_peer = 0; in_tgt = '0; in_posted = 0; in_tag = '0;
    byp_ready = 0; br_ready = 0; cpl_valid = 0; cpl_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: empty queues and a free bridge slot after reset
    chk(byp_valid == 1'b0, "R11 byp_valid", byp_valid, 0);
    chk(br_valid == 1'b0, "R11 br_valid", br_valid, 0);
    in_valid = 1'b1; in_tgt = 3'd5; #1;
    chk(in_ready == 1'b1, "R11 bridge slot free", in_ready, 1);
    in_valid = 1'b0;

    // R8: fill bypass queue, fifth request held
    for (int i = 0; i < 5; i++) cyc(1, i[0], i, i[1], i + 1, 0, 0, 0, 0);
    // R2/R7: one bridge request taken, second held while slot busy
    cyc(1, 0, 5, 0, 9, 0, 0, 0, 0);
    cyc(1, 0, 5, 0, 10, 0, 1, 0, 0);
    cyc(1, 0, 5, 0, 10, 0, 0, 0, 0);
    // R8: bypass drains and accepts while the bridge slot stays taken
    cyc(1, 1, 2, 1, 11, 1, 0, 0, 0);
    cyc(1, 0, 4, 0, 12, 1, 0, 0, 0);
    // R10: stray completion, then R9: matching completion and reuse next cycle
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 3);
    cyc(1, 0, 5, 0, 13, 1, 0, 1, 9);
    cyc(1, 0, 5, 0, 13, 1, 0, 0, 0);
    // R3, R4, R5 reject reasons and precedence
    cyc(1, 0, 5, 1, 14, 1, 1, 0, 0);
    cyc(1, 1, 5, 0, 15, 1, 1, 0, 0);
    cyc(1, 1, 5, 1, 1, 1, 1, 0, 0);
    cyc(1, 0, 6, 0, 2, 1, 1, 0, 0);
    cyc(1, 1, 7, 1, 3, 1, 1, 1, 13);
    idle(4);

    // random mix
    for (int n = 0; n < 5000; n++) begin
      int r, tgt, ctag;
      bit cv;
      r    = $urandom_range(0, 99);
      tgt  = (r < 35) ? 5 : $urandom_range(0, 7);
      cv   = ($urandom_range(0, 99) < 15);
      ctag = (m_out.size() > 0 && $urandom_range(0, 3) != 0) ? int'(m_out[0]) : $urandom_range(0, 15);
      cyc($urandom_range(0, 99) < 80, $urandom_range(0, 99) < 20, tgt,
          $urandom_range(0, 99) < 20, $urandom_range(0, 15),
          $urandom_range(0, 99) < 60, $urandom_range(0, 99) < 50, cv, ctag);
    end
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule